// File: doc/BRIEF.md
# USB Charger Detection Sequencer

This block classifies the USB port a portable device has been plugged into. It stays dormant until the VBUS-valid flag rises. It then runs three phases: a data-contact check, a primary voltage probe and, when needed, a secondary voltage probe. At the end it reports one of three port kinds: a standard downstream port (an ordinary host), a charging downstream port (a host that also charges), or a dedicated charger.

The analog comparators stay outside the block. The block samples their digitized outputs through a two-flop synchronizer and drives the enables for three analog sources:

- the weak pull-up current source on D+ used for contact detection;
- the D+ voltage source;
- the D- voltage source.

Every duration is a parameter counted in pulses of an external time-base tick. With the default values and a 1 ms tick, the durations are a 450 ms contact timeout, a 10 ms debounce and 40 ms for each probe. A one-cycle done strobe marks the moment the classification becomes valid. The classification then holds until VBUS-valid falls. A loss of VBUS at any point stops the sequence in the following cycle and reports nothing.

All pins are plain control and status signals. There is no data stream, so no valid/ready handshake and no back-pressure apply.

Top module: `chgdet_seq`

## Requirements
- R1: After reset, and in every cycle in which `vbus_ok_i` was sampled low, all three source enables and `done_o` are low and `port_type_o` reads 00 (no result).
- R2: One cycle after `vbus_ok_i` is first sampled high, `contact_src_en_o` rises. The contact phase ends once D+ has been below the logic threshold (`dp_lgc_i` low) for DBNC_TICKS consecutive ticks.
- R3: If D+ never stays low long enough, the contact phase ends after CONTACT_TMO_TICKS ticks. The sequence then continues to the primary probe and is not aborted.
- R4: The primary probe enables the D+ source for PRI_TICKS ticks and then judges D-. D- inside the window (`dm_ref_i` high and `dm_lgc_i` low) means a charger is present. Any other D- level ends the sequence with a standard downstream port, code 01.
- R5: The secondary probe enables the D- source for SEC_TICKS ticks and then judges D+. D+ inside the window (`dp_ref_i` high and `dp_lgc_i` low) gives a dedicated charger, code 11. Any other D+ level gives a charging downstream port, code 10.
- R6: `done_o` is high for exactly one cycle, in the cycle in which `port_type_o` first shows a nonzero code. That code then holds while `vbus_ok_i` stays high.
- R7: At most one source enable is high in any cycle. A cycle with all enables low separates any two different enables.
- R8: A low `vbus_ok_i` in any phase clears all enables and `port_type_o` in the next cycle, with no `done_o`. A later rise of `vbus_ok_i` starts a fresh sequence.
- R9: When contact is already made, `done_o` rises no later than DBNC_TICKS+PRI_TICKS+SEC_TICKS ticks plus 8 clock cycles after `vbus_ok_i` rises. With the default parameters this is 90 ms, inside a 250 ms limit.
- R10: A port that leaves both data lines floating, or pulls both of them high, is classified as a standard downstream port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Time-base pulse, one cycle wide, counted by all phase durations |
| vbus_ok_i | input | 1 | VBUS above the valid threshold (synchronous) |
| dp_ref_i | input | 1 | Comparator: D+ above data reference |
| dp_lgc_i | input | 1 | Comparator: D+ above logic threshold |
| dm_ref_i | input | 1 | Comparator: D- above data reference |
| dm_lgc_i | input | 1 | Comparator: D- above logic threshold |
| contact_src_en_o | output | 1 | Enable for the D+ contact-detect current source |
| dp_src_en_o | output | 1 | Enable for the D+ voltage source |
| dm_src_en_o | output | 1 | Enable for the D- voltage source |
| done_o | output | 1 | One-cycle strobe: classification valid |
| port_type_o | output | 2 | 00 none, 01 standard downstream, 10 charging downstream, 11 dedicated charger |

## Verification
The secondary-probe verdict and a VBUS loss can fall on the same clock edge. In that case the abort must win: no strobe is issued and no code is reported. The bench provokes this by counting the ticks it hands out while the D- source is on. It lowers `vbus_ok_i` just before the edge that would judge D+. It then expects `port_type_o` at 00 with no `done_o` seen, and afterwards a clean restart of the sequence. Randomly timed aborts in earlier phases, together with the one-cycle break between sources, are judged in the same way.

// File: rtl/chgdet_pkg.sv
package chgdet_pkg;

  typedef enum logic [1:0] {
    PORT_NONE = 2'd0,
    PORT_SDP  = 2'd1,
    PORT_CDP  = 2'd2,
    PORT_DCP  = 2'd3
  } port_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONTACT,
    ST_GAP_P,
    ST_PRIMARY,
    ST_GAP_S,
    ST_SECONDARY,
    ST_RESULT
  } seq_state_e;

  typedef struct packed {
    logic contact;
    logic dp_src;
    logic dm_src;
  } src_en_t;

  function automatic src_en_t src_for_state(seq_state_e st);
    src_en_t e;
    e.contact = (st == ST_CONTACT);
    e.dp_src  = (st == ST_PRIMARY);
    e.dm_src  = (st == ST_SECONDARY);
    return e;
  endfunction

endpackage

// File: rtl/chgdet_sync.sv
module chgdet_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/chgdet_timer.sv
module chgdet_timer #(
  parameter int CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;

  // Saturating tick counter, cleared whenever its phase is not active.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!run_i)                      cnt_q <= '0;
    else if (tick_i && cnt_q != limit_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = run_i && (cnt_q == limit_i);
endmodule

// File: rtl/chgdet_debounce.sv
module chgdet_debounce #(
  parameter int TICKS = 10,
  localparam int DW   = $clog2(TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic low_i,
  output logic stable_o
);
  localparam logic [DW-1:0] LIMIT = DW'(TICKS);
  logic [DW-1:0] cnt_q;

  // Counts ticks of an unbroken low level; any high restarts the window.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!run_i || !low_i)       cnt_q <= '0;
    else if (tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign stable_o = run_i && low_i && (cnt_q == LIMIT);
endmodule

// File: rtl/chgdet_fsm.sv
module chgdet_fsm
  import chgdet_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vbus_ok_i,
  input  logic       contact_ok_i,
  input  logic       timer_hit_i,
  input  logic       dm_window_i,
  input  logic       dp_window_i,
  output seq_state_e state_o,
  output src_en_t    src_en_o,
  output logic       done_o,
  output port_kind_e kind_o
);
  seq_state_e state_q, state_d;
  port_kind_e kind_q, kind_d;
  src_en_t    en_q;
  logic       done_q;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    if (!vbus_ok_i) begin
      state_d = ST_IDLE;
      kind_d  = PORT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_CONTACT;
          kind_d  = PORT_NONE;
        end
        ST_CONTACT:
          if (contact_ok_i || timer_hit_i) state_d = ST_GAP_P;
        ST_GAP_P:
          state_d = ST_PRIMARY;
        ST_PRIMARY:
          if (timer_hit_i) begin
            if (dm_window_i) state_d = ST_GAP_S;
            else begin
              state_d = ST_RESULT;
              kind_d  = PORT_SDP;
            end
          end
        ST_GAP_S:
          state_d = ST_SECONDARY;
        ST_SECONDARY:
          if (timer_hit_i) begin
            state_d = ST_RESULT;
            kind_d  = dp_window_i ? PORT_DCP : PORT_CDP;
          end
        ST_RESULT:
          state_d = ST_RESULT;
        default: begin
          state_d = ST_IDLE;
          kind_d  = PORT_NONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= PORT_NONE;
      en_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      en_q    <= src_for_state(state_d);
      done_q  <= (state_d == ST_RESULT) && (state_q != ST_RESULT);
    end
  end

  assign state_o  = state_q;
  assign src_en_o = en_q;
  assign done_o   = done_q;
  assign kind_o   = kind_q;
endmodule

// File: rtl/chgdet_seq.sv
module chgdet_seq
  import chgdet_pkg::*;
#(
  parameter int CONTACT_TMO_TICKS = 450,
  parameter int DBNC_TICKS        = 10,
  parameter int PRI_TICKS         = 40,
  parameter int SEC_TICKS         = 40,
  parameter int SYNC_STAGES       = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       vbus_ok_i,
  input  logic       dp_ref_i,
  input  logic       dp_lgc_i,
  input  logic       dm_ref_i,
  input  logic       dm_lgc_i,
  output logic       contact_src_en_o,
  output logic       dp_src_en_o,
  output logic       dm_src_en_o,
  output logic       done_o,
  output logic [1:0] port_type_o
);
  localparam int MAXT = (CONTACT_TMO_TICKS > PRI_TICKS)
                      ? ((CONTACT_TMO_TICKS > SEC_TICKS) ? CONTACT_TMO_TICKS : SEC_TICKS)
                      : ((PRI_TICKS > SEC_TICKS) ? PRI_TICKS : SEC_TICKS);
  localparam int CW = $clog2(MAXT + 1);
  localparam int NCMP = 4;

  logic [NCMP-1:0] cmp_s;
  logic dp_ref_s, dp_lgc_s, dm_ref_s, dm_lgc_s;
  seq_state_e state;
  src_en_t    src_en;
  port_kind_e kind;
  logic       timer_run, timer_hit, contact_ok;
  logic [CW-1:0] limit;

  chgdet_sync #(.W(NCMP), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dp_ref_i, dp_lgc_i, dm_ref_i, dm_lgc_i}),
    .q_o   (cmp_s)
  );
  assign {dp_ref_s, dp_lgc_s, dm_ref_s, dm_lgc_s} = cmp_s;

  always_comb begin
    unique case (state)
      ST_CONTACT:   limit = CW'(CONTACT_TMO_TICKS);
      ST_PRIMARY:   limit = CW'(PRI_TICKS);
      ST_SECONDARY: limit = CW'(SEC_TICKS);
      default:      limit = '0;
    endcase
  end
  assign timer_run = (state == ST_CONTACT) || (state == ST_PRIMARY) ||
                     (state == ST_SECONDARY);

  chgdet_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (timer_run),
    .tick_i (tick_i),
    .limit_i(limit),
    .hit_o  (timer_hit)
  );

  chgdet_debounce #(.TICKS(DBNC_TICKS)) u_dbnc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state == ST_CONTACT),
    .tick_i  (tick_i),
    .low_i   (!dp_lgc_s),
    .stable_o(contact_ok)
  );

  chgdet_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vbus_ok_i   (vbus_ok_i),
    .contact_ok_i(contact_ok),
    .timer_hit_i (timer_hit),
    .dm_window_i (dm_ref_s && !dm_lgc_s),
    .dp_window_i (dp_ref_s && !dp_lgc_s),
    .state_o     (state),
    .src_en_o    (src_en),
    .done_o      (done_o),
    .kind_o      (kind)
  );

  assign contact_src_en_o = src_en.contact;
  assign dp_src_en_o      = src_en.dp_src;
  assign dm_src_en_o      = src_en.dm_src;
  assign port_type_o      = kind;
endmodule

// File: rtl/chgdet_seq_chk.sv
module chgdet_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vbus_ok_i,
  input logic       contact_src_en_o,
  input logic       dp_src_en_o,
  input logic       dm_src_en_o,
  input logic       done_o,
  input logic [1:0] port_type_o
);
  // R7
  excl_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({contact_src_en_o, dp_src_en_o, dm_src_en_o}));
  // R7
  gap_contact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(contact_src_en_o) |-> !dp_src_en_o && !dm_src_en_o);
  // R7
  gap_dp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dp_src_en_o) |-> !contact_src_en_o && !dm_src_en_o);
  // R7
  gap_dm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dm_src_en_o) |-> !contact_src_en_o && !dp_src_en_o);
  // R8
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vbus_ok_i |=> !contact_src_en_o && !dp_src_en_o && !dm_src_en_o &&
                   !done_o && port_type_o == 2'd0);
  // R2
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vbus_ok_i) |=> contact_src_en_o);
  // R6
  strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  code_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> port_type_o != 2'd0 && $past(port_type_o) == 2'd0);
  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vbus_ok_i && port_type_o != 2'd0) |=> $stable(port_type_o));
endmodule

bind chgdet_seq chgdet_seq_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .vbus_ok_i       (vbus_ok_i),
  .contact_src_en_o(contact_src_en_o),
  .dp_src_en_o     (dp_src_en_o),
  .dm_src_en_o     (dm_src_en_o),
  .done_o          (done_o),
  .port_type_o     (port_type_o)
);

// File: tb/chgdet_seq_test.sv
`timescale 1ns/1ps
module chgdet_seq_test;
  localparam int TMO  = 20;
  localparam int DBNC = 4;
  localparam int PRI  = 6;
  localparam int SEC  = 5;
  localparam int DIV  = 4;     // clocks per tick
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, vbus = 1'b0;
  logic dp_ref, dp_lgc, dm_ref, dm_lgc;
  logic c_en, p_en, m_en, done;
  logic [1:0] ptype;

  // scenario: contact made, D- level in primary, D+ level in secondary
  // levels: 0 below reference, 1 inside window, 2 above logic threshold
  logic       sc_contact = 1'b1;
  logic [1:0] sc_pri = 2'd0, sc_sec = 2'd0;
  logic [1:0] dp_lvl, dm_lvl;

  assign dp_lvl = m_en ? sc_sec : (sc_contact ? 2'd0 : 2'd2);
  assign dm_lvl = p_en ? sc_pri : 2'd0;
  assign dp_ref = dp_lvl >= 2'd1;
  assign dp_lgc = dp_lvl == 2'd2;
  assign dm_ref = dm_lvl >= 2'd1;
  assign dm_lgc = dm_lvl == 2'd2;

  always #5 clk = ~clk;

  chgdet_seq #(.CONTACT_TMO_TICKS(TMO), .DBNC_TICKS(DBNC),
               .PRI_TICKS(PRI), .SEC_TICKS(SEC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .vbus_ok_i(vbus),
    .dp_ref_i(dp_ref), .dp_lgc_i(dp_lgc), .dm_ref_i(dm_ref), .dm_lgc_i(dm_lgc),
    .contact_src_en_o(c_en), .dp_src_en_o(p_en), .dm_src_en_o(m_en),
    .done_o(done), .port_type_o(ptype));

  int n_chk = 0, n_fail = 0;
  int tdiv = 0, cyc = 0;
  int t_c, t_p, t_m, n_done, done_cyc;
  logic [1:0] done_type;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle: drive the tick for the coming edge, count ticks per active source
  task automatic step();
    @(negedge clk);
    tick = (tdiv == DIV - 1);
    tdiv = (tdiv + 1) % DIV;
    cyc++;
    if (tick && c_en) t_c++;
    if (tick && p_en) t_p++;
    if (tick && m_en) t_m++;
    if (done) begin
      n_done++;
      done_type = ptype;
      done_cyc  = cyc;
    end
  endtask

  function automatic logic [1:0] expect_kind(logic [1:0] pri, logic [1:0] sec);
    if (pri != 2'd1) return 2'd1;          // standard downstream
    return (sec == 2'd1) ? 2'd3 : 2'd2;    // dedicated : charging downstream
  endfunction

  task automatic idle_off(input string req);
    chk(!c_en && !p_en && !m_en && !done && ptype == 2'd0, req,
        {28'd0, c_en, p_en, m_en, done} * 4 + ptype, 0);
  endtask

  // mode 0 normal, 1 abort at cycle abort_at, 2 abort on the secondary verdict edge
  task automatic trial(input bit contact, input logic [1:0] pri, input logic [1:0] sec,
                       input int mode, input int abort_at);
    int start;
    bit cut;
    logic [1:0] exp_k;
    vbus = 1'b0;
    sc_contact = contact; sc_pri = pri; sc_sec = sec;
    repeat (4) step();
    t_c = 0; t_p = 0; t_m = 0; n_done = 0; done_type = 2'd0;
    vbus = 1'b1;
    start = cyc;
    cut = 0;
    for (int i = 0; i < 400 && n_done == 0 && !cut; i++) begin
      step();
      if (mode == 1 && cyc - start == abort_at) cut = 1;
      if (mode == 2 && m_en && t_m == SEC) begin
        step();
        cut = 1;
      end
    end
    exp_k = expect_kind(pri, sec);
    if (cut) begin
      vbus = 1'b0;
      step();
      idle_off("R8 abort clears outputs");
      repeat (3) step();
      chk(n_done == 0, "R8 no strobe on abort", n_done, 0);
      if (mode == 2)
        chk(ptype == 2'd0, "R8 abort beats secondary verdict", ptype, 0);
      return;
    end
    chk(n_done == 1, "R6 one done strobe", n_done, 1);
    chk(done_type == exp_k, "R4/R5 port kind", done_type, exp_k);
    if (!contact && pri == 2'd0)
      chk(done_type == 2'd1, "R10 floating lines give standard port", done_type, 1);
    if (pri == 2'd2 && !contact)
      chk(done_type == 2'd1, "R10 both lines high give standard port", done_type, 1);
    chk(t_c == (contact ? DBNC : TMO), contact ? "R2 debounce length" : "R3 timeout length",
        t_c, contact ? DBNC : TMO);
    chk(t_p == PRI, "R4 primary length", t_p, PRI);
    chk(t_m == ((pri == 2'd1) ? SEC : 0), "R5 secondary length", t_m,
        (pri == 2'd1) ? SEC : 0);
    if (contact)
      chk(done_cyc - start <= (DBNC + PRI + SEC) * DIV + 8, "R9 latency bound",
          done_cyc - start, (DBNC + PRI + SEC) * DIV + 8);
    repeat (6) step();
    chk(ptype == exp_k && n_done == 1, "R6 code holds, no repeat strobe", ptype, exp_k);
    vbus = 1'b0;
    step();
    idle_off("R1 idle after vbus loss");
  endtask

  initial begin
    #(WD_CYCLES * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0021);
    repeat (3) step();
    idle_off("R1 reset state");
    rst_n = 1'b1;
    repeat (20) step();
    idle_off("R1 idle without vbus");

    trial(1, 2'd1, 2'd1, 0, 0);   // dedicated charger
    trial(1, 2'd1, 2'd0, 0, 0);   // charging downstream
    trial(1, 2'd1, 2'd2, 0, 0);   // charging downstream, D+ high in secondary
    trial(1, 2'd0, 2'd0, 0, 0);   // standard downstream
    trial(0, 2'd0, 2'd0, 0, 0);   // R10 floating, timeout path R3
    trial(0, 2'd2, 2'd2, 0, 0);   // R10 both lines high
    trial(0, 2'd1, 2'd1, 0, 0);   // R3 timeout then dedicated charger
    trial(1, 2'd1, 2'd1, 1, 2);   // R8 abort in contact phase
    trial(1, 2'd1, 2'd1, 2, 0);   // R8 abort on the verdict edge
    trial(1, 2'd1, 2'd0, 0, 0);   // R8 restart after abort

    for (int k = 0; k < 50; k++) begin
      bit c;
      logic [1:0] a, b;
      int ab;
      c = ($urandom % 4) != 0;
      a = 2'($urandom % 3);
      b = 2'($urandom % 3);
      ab = ($urandom % 4 == 0) ? 1 + int'($urandom % 30) : 0;
      trial(c, a, b, (ab != 0) ? 1 : 0, ab);
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule